// File: doc/BRIEF.md
# Timing Source Selector with Test Pulse Generator

This block sits between the incoming machine timing lines and the processing units that consume them. Eight lines pass through it: a 10 MHz reference tick, six cycle event lines and the orbit reference. For each line, a single 32-bit control word picks either the external input or a source from inside the block. The six event lines take their test value from software-written levels in the same word. The tick line uses a free-running on-chip divider. The orbit line uses a programmable pulse generator.

The orbit test pulse stays high for a fixed number of clock cycles (default 8) out of every N cycles. N is a 16-bit field of the control word. Each output line has its own flop, so a change of source never shows up as a glitch downstream. The control word is write-only from the block's point of view. There is no data stream, so every pin is a plain level or strobe.

Top module: `tsel_timing_src`

## Requirements
- R1: While `rst_n` is low, every output is 0 and the control word is cleared, so all selects are clear after reset.
- R2: Control bits 1 through 6 hold software levels for the event outputs `evt_o[0]` through `evt_o[5]`, in this order: cycle start, cycle stop, calibration start, calibration stop, injection, field change.
- R3: Bits 9 through 14 select, per event line `evt_o[i]` (bit 9+i), the software level when set and the external input `ext_evt[i]` when clear. Each line is chosen independently of the others.
- R4: Bit 8 selects the internal tick. The internal tick is high for TICK_HI cycles, then low for TICK_LO cycles, and repeats. It runs freely from reset.
- R5: Bit 15 selects the internal orbit pulse for `orbit_o`. When bit 15 is clear, `ext_orbit` passes through.
- R6: Bits 16 through 31 hold the period N. For N > PULSE_HIGH, the orbit pulse is high for PULSE_HIGH cycles and then low for N-PULSE_HIGH cycles, repeating.
- R7: For 1 <= N <= PULSE_HIGH, the orbit pulse is high continuously.
- R8: For N = 0, the orbit pulse is low continuously.
- R9: A write whose period field differs from the held one restarts the pulse at the first cycle of its high phase. A write with the same period leaves the phase undisturbed.
- R10: Each output is registered. An external input sampled at a clock edge appears after that edge. A write takes effect on the outputs one edge after the write edge. Bits 0 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word value written when `cfg_wr` is high |
| ext_tick | input | 1 | External 10 MHz reference tick |
| ext_evt | input | 6 | External cycle event lines, in the R2 order |
| ext_orbit | input | 1 | External orbit reference |
| tick_o | output | 1 | Selected tick |
| evt_o | output | 6 | Selected event lines |
| orbit_o | output | 1 | Selected orbit reference |

## Verification
Two functions can act on the same edge: a period rewrite that restarts the orbit counter, and the counter's own wrap at the end of the period. The bench provokes this by timing a write with a new period to land exactly on the wrap edge. It also flips event selects on edges where the matching external lines toggle. A behavioural model predicts the outcome of both collisions on every cycle, and window counts of the orbit pulse confirm the restart.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  localparam int EVT_N = 6;
  localparam int PER_W = 16;

  // Control word layout; field positions are part of the software contract.
  typedef struct packed {
    logic [PER_W-1:0] period;   // 31:16
    logic             sel_orb;  // 15
    logic [EVT_N-1:0] sel_evt;  // 14:9
    logic             sel_tick; // 8
    logic             rsv_hi;   // 7, ignored
    logic [EVT_N-1:0] lvl_evt;  // 6:1
    logic             rsv_lo;   // 0, ignored
  } tsel_cfg_t;

  localparam int CFG_W = $bits(tsel_cfg_t);
endpackage

// File: rtl/tsel_cfg_reg.sv
module tsel_cfg_reg
  import tsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output tsel_cfg_t        cfg,
  output logic             restart
);
  tsel_cfg_t wr_cfg;

  always_comb begin
    wr_cfg        = tsel_cfg_t'(wr_data);
    wr_cfg.rsv_hi = 1'b0;
    wr_cfg.rsv_lo = 1'b0;
  end

  // A new period restarts the pulse counter on the same edge it is stored.
  assign restart = wr_en && (wr_cfg.period != cfg.period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_en) cfg <= wr_cfg;
  end
endmodule

// File: rtl/tsel_pulse_gen.sv
module tsel_pulse_gen #(
  parameter int PER_W  = 16,
  parameter int HIGH_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  input  logic             restart,
  output logic             lvl
);
  localparam logic [PER_W-1:0] HIGH_V = PER_W'(HIGH_W);
  localparam logic [PER_W-1:0] ONE_V  = PER_W'(1);

  logic [PER_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (restart || period == '0) cnt <= '0;
    else if (cnt >= period - ONE_V)    cnt <= '0;
    else                               cnt <= cnt + ONE_V;
  end

  assign lvl = (period != '0) && (cnt < HIGH_V);
endmodule

// File: rtl/tsel_tick_gen.sv
module tsel_tick_gen #(
  parameter int TICK_HI = 6,
  parameter int TICK_LO = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic lvl
);
  localparam int TOT = TICK_HI + TICK_LO;
  localparam int CW  = (TOT > 1) ? $clog2(TOT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TOT - 1);
  localparam logic [CW-1:0] HI_V = CW'(TICK_HI);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end

  assign lvl = (cnt < HI_V);
endmodule

// File: rtl/tsel_line_sel.sv
module tsel_line_sel #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] ext_in,
  input  logic [LINES-1:0] tst_in,
  input  logic [LINES-1:0] sel,
  output logic [LINES-1:0] q
);
  logic [LINES-1:0] pick;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign pick[i] = sel[i] ? tst_in[i] : ext_in[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= pick;
  end
endmodule

// File: rtl/tsel_timing_src.sv
module tsel_timing_src
  import tsel_pkg::*;
#(
  parameter int TICK_HI    = 6,
  parameter int TICK_LO    = 6,
  parameter int PULSE_HIGH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  input  logic             ext_tick,
  input  logic [5:0]       ext_evt,
  input  logic             ext_orbit,
  output logic             tick_o,
  output logic [5:0]       evt_o,
  output logic             orbit_o
);
  localparam int LINES = EVT_N + 2;

  tsel_cfg_t        cfg_q;
  logic             restart_w;
  logic             orb_lvl_w;
  logic             tick_lvl_w;
  logic [LINES-1:0] q_w;

  tsel_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_data (cfg_wdata),
    .cfg     (cfg_q),
    .restart (restart_w)
  );

  tsel_pulse_gen #(.PER_W(PER_W), .HIGH_W(PULSE_HIGH)) u_orb (
    .clk     (clk),
    .rst_n   (rst_n),
    .period  (cfg_q.period),
    .restart (restart_w),
    .lvl     (orb_lvl_w)
  );

  tsel_tick_gen #(.TICK_HI(TICK_HI), .TICK_LO(TICK_LO)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (tick_lvl_w)
  );

  // Line order: orbit, six events, tick.
  tsel_line_sel #(.LINES(LINES)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_in ({ext_orbit, ext_evt, ext_tick}),
    .tst_in ({orb_lvl_w, cfg_q.lvl_evt, tick_lvl_w}),
    .sel    ({cfg_q.sel_orb, cfg_q.sel_evt, cfg_q.sel_tick}),
    .q      (q_w)
  );

  assign tick_o  = q_w[0];
  assign evt_o   = q_w[EVT_N:1];
  assign orbit_o = q_w[LINES-1];
endmodule

// File: rtl/tsel_timing_src_chk.sv
module tsel_timing_src_chk #(
  parameter int TICK_HI    = 6,
  parameter int PULSE_HIGH = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] period,
  input logic        sel_orb,
  input logic        restart,
  input logic        orb_lvl,
  input logic        ext_orbit,
  input logic        orbit_o,
  input logic [5:0]  sel_evt,
  input logic [5:0]  lvl_evt,
  input logic [5:0]  ext_evt,
  input logic [5:0]  evt_o,
  input logic        tick_lvl
);
  logic [15:0] orb_run;
  logic [15:0] tick_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orb_run  <= '0;
      tick_run <= '0;
    end else begin
      if (restart || !orb_lvl)   orb_run <= '0;
      else if (orb_run != 16'hFFFF) orb_run <= orb_run + 16'd1;
      if (!tick_lvl)             tick_run <= '0;
      else if (tick_run != 16'hFFFF) tick_run <= tick_run + 16'd1;
    end
  end

  // R8
  period_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period == 16'd0) |-> !orb_lvl);

  // R7
  short_period_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period != 16'd0 && period <= 16'(PULSE_HIGH)) |-> orb_lvl);

  // R9
  restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (period == 16'd0 || orb_lvl));

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period > 16'(PULSE_HIGH)) |-> (orb_run <= 16'(PULSE_HIGH)));

  // R5
  orbit_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (orbit_o == ($past(sel_orb) ? $past(orb_lvl) : $past(ext_orbit))));

  // R3
  evt_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_o == (($past(sel_evt) & $past(lvl_evt)) | (~$past(sel_evt) & $past(ext_evt)))));

  // R4
  tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_run <= 16'(TICK_HI));
endmodule

bind tsel_timing_src tsel_timing_src_chk #(.TICK_HI(TICK_HI), .PULSE_HIGH(PULSE_HIGH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .period    (cfg_q.period),
  .sel_orb   (cfg_q.sel_orb),
  .restart   (restart_w),
  .orb_lvl   (orb_lvl_w),
  .ext_orbit (ext_orbit),
  .orbit_o   (orbit_o),
  .sel_evt   (cfg_q.sel_evt),
  .lvl_evt   (cfg_q.lvl_evt),
  .ext_evt   (ext_evt),
  .evt_o     (evt_o),
  .tick_lvl  (tick_lvl_w)
);

// File: tb/tsel_timing_src_tb_top.sv
module tsel_timing_src_tb_top;
  localparam int THI = 6;
  localparam int TLO = 6;
  localparam int PH  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        ext_tick = 1'b0;
  logic [5:0]  ext_evt = '0;
  logic        ext_orbit = 1'b0;
  logic        tick_o, orbit_o;
  logic [5:0]  evt_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit hold = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  tsel_timing_src #(.TICK_HI(THI), .TICK_LO(TLO), .PULSE_HIGH(PH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .ext_tick(ext_tick), .ext_evt(ext_evt), .ext_orbit(ext_orbit),
    .tick_o(tick_o), .evt_o(evt_o), .orbit_o(orbit_o)
  );

  always #2 clk = ~clk;

  // Behavioural reference model
  logic [31:0] m_cfg = '0;
  int          m_oc = 0;
  int          m_tc = 0;
  logic        e_tick = 1'b0, e_orb = 1'b0;
  logic [5:0]  e_evt = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_oc = 0; m_tc = 0;
      e_tick = 1'b0; e_orb = 1'b0; e_evt = '0;
    end else begin
      int  n;
      bit  ol, tl;
      n  = int'(m_cfg[31:16]);
      ol = (n != 0) && (m_oc < PH);
      tl = (m_tc < THI);
      for (int i = 0; i < 6; i++) e_evt[i] = m_cfg[9+i] ? m_cfg[1+i] : ext_evt[i];
      e_tick = m_cfg[8]  ? tl : ext_tick;
      e_orb  = m_cfg[15] ? ol : ext_orbit;
      if (cfg_wr && int'(cfg_wdata[31:16]) != n) m_oc = 0;
      else if (n == 0)                           m_oc = 0;
      else if (m_oc >= n - 1)                    m_oc = 0;
      else                                       m_oc = m_oc + 1;
      m_tc = (m_tc == THI + TLO - 1) ? 0 : m_tc + 1;
      if (cfg_wr) m_cfg = cfg_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(tick_o == e_tick, "R4 tick model", tick_o, e_tick);
      check(evt_o == e_evt, "R3 evt model", evt_o, e_evt);
      check(orbit_o == e_orb, "R5 orbit model", orbit_o, e_orb);
    end
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic cyc();
    @(negedge clk);
    if (!hold) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ext_tick  = lfsr[0];
      ext_evt   = lfsr[6:1];
      ext_orbit = lfsr[7];
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input logic [31:0] d);
    cyc();
    cfg_wr = 1'b1; cfg_wdata = d;
    cyc();
    cfg_wr = 1'b0;
  endtask

  task automatic count_orb(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin cyc(); if (orbit_o) hi++; end
  endtask

  initial begin
    int hi;
    run(4);
    // R1: reset state
    check(tick_o == 1'b0, "R1 tick reset", tick_o, 0);
    check(evt_o == 6'd0, "R1 evt reset", evt_o, 0);
    check(orbit_o == 1'b0, "R1 orbit reset", orbit_o, 0);
    rst_n = 1'b1;
    run(30);

    // R10: one-edge latency of pass-through
    hold = 1'b1;
    cyc(); ext_evt = 6'h2A; ext_orbit = 1'b1; ext_tick = 1'b1;
    cyc();
    check(evt_o == 6'h2A, "R10 latency evt", evt_o, 6'h2A);
    // R10: bits 0 and 7 have no effect
    wr(32'h0000_0081);
    cyc();
    check(evt_o == 6'h2A, "R10 ignored bits evt", evt_o, 6'h2A);
    check(orbit_o == 1'b1 && tick_o == 1'b1, "R10 ignored bits lines", {orbit_o, tick_o}, 2'b11);

    // R2: all event selects set, software levels 100110
    wr({16'd0, 1'b0, 6'h3F, 1'b0, 1'b0, 6'b100110, 1'b0});
    cyc();
    check(evt_o == 6'b100110, "R2 sw levels", evt_o, 6'b100110);
    // R3: mixed selects, lines chosen independently
    ext_evt = 6'b000000;
    wr({16'd0, 1'b0, 6'b010101, 1'b0, 1'b0, 6'h3F, 1'b0});
    cyc();
    check(evt_o == 6'b010101, "R3 mixed select", evt_o, 6'b010101);
    hold = 1'b0;
    run(40);

    // R4: internal tick
    wr({16'd0, 1'b0, 6'b110011, 1'b1, 1'b0, 6'b001100, 1'b0});
    cyc();
    hi = 0;
    for (int i = 0; i < THI + TLO; i++) begin cyc(); if (tick_o) hi++; end
    check(hi == THI, "R4 tick duty", hi, THI);

    // R6: period 20, internal orbit
    wr({16'd20, 1'b1, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0});
    cyc();
    count_orb(20, hi);
    check(hi == PH, "R6 pulse in 20", hi, PH);
    count_orb(20, hi);
    check(hi == PH, "R6 second period", hi, PH);

    // R9: same period rewrite does not disturb phase (model compares each cycle)
    run(3);
    wr({16'd20, 1'b1, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0});
    run(25);
    // R9: new period restarts at high phase
    wr({16'd30, 1'b1, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0});
    count_orb(PH, hi);
    check(hi == PH, "R9 restart high", hi, PH);
    count_orb(1, hi);
    check(hi == 0, "R9 restart low after", hi, 0);

    // R9: new period written on the wrap edge
    while (m_oc != 29) cyc();
    cfg_wr = 1'b1; cfg_wdata = {16'd12, 1'b1, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0};
    cyc();
    cfg_wr = 1'b0;
    count_orb(PH, hi);
    check(hi == PH, "R9 restart on wrap", hi, PH);
    count_orb(4, hi);
    check(hi == 0, "R6 low tail of 12", hi, 0);

    // R7: short periods stay high
    wr({16'd5, 1'b1, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0});
    cyc();
    count_orb(16, hi);
    check(hi == 16, "R7 period 5", hi, 16);
    wr({16'd8, 1'b1, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0});
    cyc();
    count_orb(16, hi);
    check(hi == 16, "R7 period 8", hi, 16);
    wr({16'd9, 1'b1, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0});
    cyc();
    count_orb(18, hi);
    check(hi == 16, "R6 period 9", hi, 16);

    // R8: period zero stays low
    wr({16'd0, 1'b1, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0});
    cyc();
    count_orb(30, hi);
    check(hi == 0, "R8 period 0", hi, 0);

    // R5: select back to external orbit, random stimulus
    wr({16'd15, 1'b0, 6'h15, 1'b1, 1'b0, 6'h2A, 1'b0});
    run(60);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule